// File: doc/BRIEF.md
# Serial Link Test Pattern Generator and Checker

This block sits beside a serializer/deserializer pair and exercises the link one unit interval per clock. On the transmit side it produces a selectable bit pattern. On the receive side it predicts the incoming stream and keeps a fail flag. A 3-bit mode input chooses the pattern. The choices are a 2-UI toggle, three maximal-length PRBS sequences, and a programmable 20-bit word that repeats. Mode 000 and the two reserved codes keep both sides idle.

The receive checker needs no shared start point with the transmitter. For the toggle and PRBS modes it fills its shift register from the first received bits and then predicts each later bit from earlier received bits. For the user word it slides a 20-bit window over the stream until the programmed word appears. After that it follows the word bit by bit. The fail flag holds until software clears it or the pattern is restarted.

Top module: `ptrn_bist`

## Requirements
- R1: With mode code 000, 110 or 111 in effect, txBit is 0, rxLocked is 0 and failFlag stays 0 whatever arrives on rxBit.
- R2: Mode 001 sends 0 in the first cycle after entry and inverts txBit every cycle after that, giving a period of 2 UI.
- R3: Mode 010 sends PRBS7 (x^7+x^6+1): each bit equals the XOR of the bits sent 7 and 6 cycles earlier. The generator register starts from all ones on entry, so the first bit is 0.
- R4: Mode 011 sends PRBS23 (x^23+x^18+1): each bit is the XOR of the bits sent 23 and 18 cycles earlier, starting from an all-ones register.
- R5: Mode 100 sends PRBS31 (x^31+x^28+1): each bit is the XOR of the bits sent 31 and 28 cycles earlier, starting from an all-ones register.
- R6: Mode 101 repeats a 20-bit user word MSB first (bit 19 first), starting at bit 19 on entry. After reset the word is 0x66666.
- R7: A cycle with userWr high loads userData into the user word and restarts the pattern. The next cycle sends bit 19 of the new word.
- R8: In modes 001 to 100 the checker takes the first N received bits as seed (N = 1, 7, 23, 31). rxLocked is 0 after N-1 bits and 1 after N bits.
- R9: In mode 101 rxLocked rises after the cycle in which the last 20 received bits, oldest first, equal the user word.
- R10: Once rxLocked is 1, a received bit that differs from the predicted bit sets failFlag at the next clock edge. failFlag then stays 1.
- R11: A cycle with clearFail high leaves failFlag 0 at the next edge, even when a mismatch arrives in that cycle.
- R12: A change of modeSel, or a userWr pulse, takes effect at the next edge. That edge clears failFlag and rxLocked and restarts the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one unit interval per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Pattern mode code |
| userWr | input | 1 | Load strobe for the user word |
| userData | input | USER_W | New user word |
| clearFail | input | 1 | Clears the fail flag |
| txBit | output | 1 | Generated bit for the serializer |
| rxBit | input | 1 | Received bit from the deserializer |
| failFlag | output | 1 | Sticky mismatch flag |
| rxLocked | output | 1 | Checker has seeded or aligned |

## Verification
The transmit stream of every mode is compared bit by bit with a model in the bench. Matching the toggle and the three PRBS polynomials separates wrong taps, a wrong seed and a wrong shift direction. Running the default user word and a written word separates bit order from restart behaviour. Single flipped bits are injected into a looped-back link. These show that the flag rises only after lock and that it holds. They also show that clearing wins over a mismatch in the same cycle. Off and reserved codes are driven with a noisy receive stream to show the flag stays low. A mode switch with the flag raised shows the restart clearing it.

// File: rtl/ptrn_pkg.sv
package ptrn_pkg;

  localparam int LFSR_W = 31;
  localparam int TAP_W  = 5;

  typedef logic [2:0] mode_t;

  localparam mode_t MODE_OFF  = 3'b000;
  localparam mode_t MODE_ALT  = 3'b001;
  localparam mode_t MODE_P7   = 3'b010;
  localparam mode_t MODE_P23  = 3'b011;
  localparam mode_t MODE_P31  = 3'b100;
  localparam mode_t MODE_USER = 3'b101;

  // strobes and decoded settings from control to datapath
  typedef struct packed {
    logic             restart;
    logic             clrFail;
    logic             chkOn;
    logic             isAlt;
    logic             isPrbs;
    logic             isUser;
    logic [TAP_W-1:0] seedLen;
    logic [TAP_W-1:0] tapHi;
    logic [TAP_W-1:0] tapLo;
  } ctl_t;

endpackage

// File: rtl/ptrn_ctrl.sv
module ptrn_ctrl
  import ptrn_pkg::*;
#(
  parameter int USER_W = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeSel,
  input  logic        userWr,
  input  logic        clearFail,
  output logic [2:0]  modeQ,
  output ctl_t        ctl
);

  localparam logic [TAP_W-1:0] USER_SEED = TAP_W'(USER_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_OFF;
    else       modeQ <= modeSel;
  end

  always_comb begin
    ctl          = '0;
    ctl.restart  = (modeSel != modeQ) | userWr;
    ctl.clrFail  = clearFail;
    unique case (modeQ)
      MODE_ALT: begin
        ctl.isAlt   = 1'b1;
        ctl.seedLen = 5'd1;
      end
      MODE_P7: begin
        ctl.isPrbs  = 1'b1;
        ctl.seedLen = 5'd7;
        ctl.tapHi   = 5'd6;
        ctl.tapLo   = 5'd5;
      end
      MODE_P23: begin
        ctl.isPrbs  = 1'b1;
        ctl.seedLen = 5'd23;
        ctl.tapHi   = 5'd22;
        ctl.tapLo   = 5'd17;
      end
      MODE_P31: begin
        ctl.isPrbs  = 1'b1;
        ctl.seedLen = 5'd31;
        ctl.tapHi   = 5'd30;
        ctl.tapLo   = 5'd27;
      end
      MODE_USER: begin
        ctl.isUser  = 1'b1;
        ctl.seedLen = USER_SEED;
      end
      default: ;
    endcase
    ctl.chkOn = ctl.isAlt | ctl.isPrbs | ctl.isUser;
  end

endmodule

// File: rtl/ptrn_dpath.sv
module ptrn_dpath
  import ptrn_pkg::*;
#(
  parameter int          USER_W    = 20,
  parameter logic [19:0] USER_INIT = 20'h66666
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              userWr,
  input  logic [USER_W-1:0] userData,
  input  logic              rxBit,
  output logic              txBit,
  output logic              failFlag,
  output logic              rxLocked
);

  localparam int PTR_W = $clog2(USER_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(USER_W - 1);

  logic [USER_W-1:0] userQ;
  logic [LFSR_W-1:0] genQ;
  logic              altQ;
  logic [PTR_W-1:0]  genPtr;
  logic              genFb;

  logic [LFSR_W-1:0] chkQ;
  logic [TAP_W-1:0]  cntQ;
  logic [TAP_W-1:0]  lastIdx;
  logic              lockQ;
  logic [PTR_W-1:0]  usrPtr;
  logic              failQ;
  logic              predBit;
  logic [USER_W-1:0] winD;

  // user word register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       userQ <= USER_INIT[USER_W-1:0];
    else if (userWr) userQ <= userData;
  end

  // transmit side
  assign genFb = genQ[ctl.tapHi] ^ genQ[ctl.tapLo];

  always_comb begin
    txBit = 1'b0;
    if (ctl.isAlt)       txBit = altQ;
    else if (ctl.isPrbs) txBit = genFb;
    else if (ctl.isUser) txBit = userQ[PTR_LAST - genPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genQ   <= '1;
      altQ   <= 1'b0;
      genPtr <= '0;
    end else if (ctl.restart) begin
      genQ   <= '1;
      altQ   <= 1'b0;
      genPtr <= '0;
    end else begin
      if (ctl.isPrbs) genQ <= {genQ[LFSR_W-2:0], genFb};
      if (ctl.isAlt)  altQ <= ~altQ;
      if (ctl.isUser) genPtr <= (genPtr == PTR_LAST) ? '0 : genPtr + 1'b1;
    end
  end

  // receive side
  assign lastIdx = ctl.seedLen - 5'd1;
  assign winD    = {chkQ[USER_W-2:0], rxBit};

  always_comb begin
    predBit = 1'b0;
    if (ctl.isAlt)       predBit = ~chkQ[0];
    else if (ctl.isPrbs) predBit = chkQ[ctl.tapHi] ^ chkQ[ctl.tapLo];
    else if (ctl.isUser) predBit = userQ[PTR_LAST - usrPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkQ   <= '0;
      cntQ   <= '0;
      lockQ  <= 1'b0;
      usrPtr <= '0;
      failQ  <= 1'b0;
    end else if (ctl.restart) begin
      chkQ   <= '0;
      cntQ   <= '0;
      lockQ  <= 1'b0;
      usrPtr <= '0;
      failQ  <= 1'b0;
    end else begin
      if (ctl.clrFail)
        failQ <= 1'b0;
      else if (lockQ && ctl.chkOn && (rxBit != predBit))
        failQ <= 1'b1;
      if (ctl.chkOn) begin
        chkQ <= {chkQ[LFSR_W-2:0], rxBit};
        if (!lockQ) begin
          if (cntQ != lastIdx) cntQ <= cntQ + 1'b1;
          if ((cntQ == lastIdx) && (!ctl.isUser || (winD == userQ))) begin
            lockQ  <= 1'b1;
            usrPtr <= '0;
          end
        end else if (ctl.isUser) begin
          usrPtr <= (usrPtr == PTR_LAST) ? '0 : usrPtr + 1'b1;
        end
      end
    end
  end

  assign failFlag = failQ;
  assign rxLocked = lockQ;

endmodule

// File: rtl/ptrn_bist.sv
module ptrn_bist
  import ptrn_pkg::*;
#(
  parameter int          USER_W    = 20,
  parameter logic [19:0] USER_INIT = 20'h66666
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              userWr,
  input  logic [USER_W-1:0] userData,
  input  logic              clearFail,
  output logic              txBit,
  input  logic              rxBit,
  output logic              failFlag,
  output logic              rxLocked
);

  ctl_t       ctl;
  logic [2:0] modeQ;

  ptrn_ctrl #(.USER_W(USER_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .userWr    (userWr),
    .clearFail (clearFail),
    .modeQ     (modeQ),
    .ctl       (ctl)
  );

  ptrn_dpath #(.USER_W(USER_W), .USER_INIT(USER_INIT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .userWr   (userWr),
    .userData (userData),
    .rxBit    (rxBit),
    .txBit    (txBit),
    .failFlag (failFlag),
    .rxLocked (rxLocked)
  );

endmodule

// File: rtl/ptrn_bist_chk.sv
module ptrn_bist_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeSel,
  input logic [2:0] modeQ,
  input logic       userWr,
  input logic       clearFail,
  input logic       txBit,
  input logic       failFlag,
  input logic       rxLocked
);

  logic idleMode;
  assign idleMode = (modeQ == 3'b000) || (modeQ[2:1] == 2'b11);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    idleMode |-> (!txBit && !failFlag && !rxLocked));

  assert_alt_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'b001 && modeSel == modeQ && !userWr) |=> (txBit != $past(txBit)));

  assert_fail_after_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> $past(rxLocked));

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !clearFail && modeSel == modeQ && !userWr) |=> failFlag);

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    clearFail |=> !failFlag);

  assert_restart_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != modeQ || userWr) |=> (!failFlag && !rxLocked));

endmodule

bind ptrn_bist ptrn_bist_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .modeQ     (modeQ),
  .userWr    (userWr),
  .clearFail (clearFail),
  .txBit     (txBit),
  .failFlag  (failFlag),
  .rxLocked  (rxLocked)
);

// File: tb/ptrn_bist_bench.sv
module ptrn_bist_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeSel = 3'b000;
  logic        userWr = 1'b0;
  logic [19:0] userData = '0;
  logic        clearFail = 1'b0;
  logic        injErr = 1'b0;
  logic        txBit, rxBit, failFlag, rxLocked;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign rxBit = txBit ^ injErr;

  ptrn_bist u_ptrn_bist (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .userWr(userWr),
    .userData(userData), .clearFail(clearFail), .txBit(txBit),
    .rxBit(rxBit), .failFlag(failFlag), .rxLocked(rxLocked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    modeSel = m;
    @(negedge clk);
  endtask

  task automatic injectOne();
    injErr = 1'b1;
    @(negedge clk);
    injErr = 1'b0;
  endtask

  // R1: reset state and idle/reserved codes ignore received noise
  task automatic testIdle(input logic [2:0] m, input string req);
    int bad = 0;
    setMode(m);
    for (int i = 0; i < 30; i++) begin
      injErr = i[0];
      if (txBit !== 1'b0 || failFlag !== 1'b0 || rxLocked !== 1'b0) bad++;
      @(negedge clk);
    end
    injErr = 1'b0;
    chk(bad == 0, req, bad, 0);
  endtask

  // R2/R8: toggle pattern and one-bit seeding
  task automatic testAlt();
    int bad = 0;
    setMode(3'b001);
    for (int i = 0; i < 16; i++) begin
      if (txBit !== i[0]) bad++;
      if (i == 1 && rxLocked !== 1'b1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R2 toggle stream", bad, 0);
    chk(failFlag == 1'b0, "R8 alt checker clean", failFlag, 0);
  endtask

  // R3/R4/R5/R8: PRBS stream vs bench model, lock timing
  task automatic testPrbs(input logic [2:0] m, input int n, input int t,
                          input int len, input string req);
    logic [30:0] model = '1;
    logic        fb;
    int          bad = 0;
    setMode(m);
    for (int i = 0; i < len; i++) begin
      fb = model[n-1] ^ model[t-1];
      if (txBit !== fb) bad++;
      model = {model[29:0], fb};
      if (i == n - 1) chk(rxLocked == 1'b0, "R8 not locked before seed done", rxLocked, 0);
      if (i == n)     chk(rxLocked == 1'b1, "R8 locked after seed", rxLocked, 1);
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
    chk(failFlag == 1'b0, "R10 no fail on clean link", failFlag, 0);
  endtask

  // R10/R11/R12: injection, stickiness, clear priority, restart
  task automatic testFail();
    setMode(3'b010);
    repeat (20) @(negedge clk);
    injectOne();
    chk(failFlag == 1'b1, "R10 fail after flipped bit", failFlag, 1);
    repeat (30) @(negedge clk);
    chk(failFlag == 1'b1, "R10 fail sticky", failFlag, 1);
    clearFail = 1'b1;
    @(negedge clk);
    clearFail = 1'b0;
    repeat (20) @(negedge clk);
    chk(failFlag == 1'b0, "R11 clear drops flag", failFlag, 0);
    clearFail = 1'b1;
    injectOne();
    clearFail = 1'b0;
    chk(failFlag == 1'b0, "R11 clear wins over mismatch", failFlag, 0);
    repeat (20) @(negedge clk);
    chk(failFlag == 1'b1, "R10 later mismatches from corrupted seed", failFlag, 1);
    setMode(3'b011);
    chk(failFlag == 1'b0 && rxLocked == 1'b0, "R12 mode change clears", failFlag, 0);
  endtask

  // R6/R7/R9: user word
  task automatic testUser();
    int bad = 0;
    logic [19:0] w = 20'h66666;
    setMode(3'b101);
    for (int i = 0; i < 60; i++) begin
      if (txBit !== w[19 - (i % 20)]) bad++;
      if (i == 19) chk(rxLocked == 1'b0, "R9 not aligned yet", rxLocked, 0);
      if (i == 20) chk(rxLocked == 1'b1, "R9 aligned after word seen", rxLocked, 1);
      @(negedge clk);
    end
    chk(bad == 0, "R6 default word MSB first", bad, 0);
    chk(failFlag == 1'b0, "R9 user checker clean", failFlag, 0);
    injectOne();
    chk(failFlag == 1'b1, "R10 user mismatch", failFlag, 1);
    w = 20'hABCDE;
    userData = w;
    userWr = 1'b1;
    @(negedge clk);
    userWr = 1'b0;
    chk(failFlag == 1'b0, "R12 write restarts", failFlag, 0);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      if (txBit !== w[19 - (i % 20)]) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 written word sent from bit 19", bad, 0);
    chk(rxLocked == 1'b1 && failFlag == 1'b0, "R9 aligned to written word", rxLocked, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txBit == 1'b0 && failFlag == 1'b0 && rxLocked == 1'b0, "R1 reset state", txBit, 0);
    rstN = 1'b1;
    @(negedge clk);
    testIdle(3'b000, "R1 off ignores noise");
    testAlt();
    testPrbs(3'b010, 7, 6, 300, "R3 PRBS7 stream");
    testPrbs(3'b011, 23, 18, 400, "R4 PRBS23 stream");
    testPrbs(3'b100, 31, 28, 400, "R5 PRBS31 stream");
    testFail();
    testUser();
    testIdle(3'b110, "R1 reserved 110 ignores noise");
    testIdle(3'b111, "R1 reserved 111 ignores noise");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule